// File: doc/BRIEF.md
# Register Rename Unit with Committed Map Recovery

This block renames architectural register names onto a larger pool of physical registers, so that the extended register file can hold speculative results in place of a reorder buffer and reservation stations. Each issued instruction has its two source names translated through a speculative map. If it writes a destination, it receives a fresh physical register from a free pool, and the register that previously held that name is reported so the pipeline can carry it to commit.

Commits arrive in program order. Each one carries the architectural destination, the new physical register and the old physical register recorded at issue. A commit moves the new register into a second, committed map and returns the old register to the free pool. A mispredicted path is discarded with a single flush cycle: the speculative map is reloaded from the committed map, and the free pool is rebuilt from the registers that the committed map does not name. No result data moves and no history is walked.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i reads physical register i, and the first register handed out is 32 (physical registers 32 to 63 start free).
- R2: A source name is translated combinationally to the physical register that the speculative map currently holds for it.
- R3: An accepted issue with a nonzero destination receives the lowest-numbered free physical register on iss_pdst and the previous mapping on iss_pold. From the next cycle, sources naming that destination read the new register.
- R4: Architectural register 0 is never renamed. As a source it reads physical 0. As a destination it yields iss_pdst = iss_pold = 0 and consumes no free register.
- R5: When the free pool is empty, an issue with a nonzero destination raises iss_stall and allocates nothing. The speculative map is left unchanged.
- R6: A commit writes the new register into the committed map and returns the old register to the free pool, where it can be allocated from the next cycle.
- R7: In a flush cycle, the speculative map is reloaded from the committed map, including any commit made in that same cycle. A valid issue in that cycle sees iss_stall high and has no effect.
- R8: After a flush, the free pool holds exactly the physical registers not named by the committed map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_src1 | input | 5 | First architectural source |
| iss_src2 | input | 5 | Second architectural source |
| iss_dst | input | 5 | Architectural destination (0 = none) |
| iss_stall | output | 1 | Issue cannot be accepted this cycle |
| iss_psrc1 | output | 6 | Physical register for first source |
| iss_psrc2 | output | 6 | Physical register for second source |
| iss_pdst | output | 6 | Physical register given to the destination |
| iss_pold | output | 6 | Previous physical register of the destination |
| cmt_valid | input | 1 | Commit present |
| cmt_arch | input | 5 | Architectural destination being committed |
| cmt_pnew | input | 6 | Physical register becoming architectural |
| cmt_pold | input | 6 | Physical register to release |
| flush | input | 1 | Discard all uncommitted mappings |

## Verification
On every cycle the assertions check the following. An allocated register is never physical 0 and leaves the free pool. The pool never grows beyond the 32 registers that the committed map leaves unused. A stall is raised whenever the pool is empty or a flush is in progress. A flush always leaves exactly 32 registers free. Only the bench scenarios can show the values themselves: the chains of renamings seen by later sources, the reuse of a committed old register, the lowest-first allocation order, and the exact map and pool contents after a flush that follows speculative work or follows exhaustion of the pool.

// File: rtl/rn_pkg.sv
// Shared sizes for the register rename unit.
// Assumes both register counts are powers of two.
package rn_pkg;
    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int AW = $clog2(ARCH_REGS);
    localparam int PW = $clog2(PHYS_REGS);
endpackage

// File: rtl/rn_lowest_pick.sv
// Priority encoder: returns the index of the lowest set bit of a vector,
// and a flag when no bit is set (index is then 0).
module rn_lowest_pick #(
    parameter int N = 64,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         none
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
        none = (vec == '0);
    end
endmodule

// File: rtl/rn_free_list.sv
// Free pool of physical registers kept as a bitmap.
// Offers the lowest free register, clears it on allocate, sets a released
// register on commit, and on flush is replaced by the complement of the
// committed-map usage vector. Assumes allocate and release never name the
// same register in one cycle.
module rn_free_list #(
    parameter int PHYS = 64,
    parameter int ARCH = 32,
    localparam int PW = $clog2(PHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic            rel_en,
    input  logic [PW-1:0]   rel_p,
    input  logic            flush,
    input  logic [PHYS-1:0] cm_used,
    output logic [PW-1:0]   cand_p,
    output logic            empty,
    output logic [PHYS-1:0] free_vec
);
    logic [PHYS-1:0] free_q;
    logic [PHYS-1:0] free_d;
    logic [PHYS-1:0] reset_vec;

    rn_lowest_pick #(.N(PHYS)) u_pick (
        .vec  (free_q),
        .idx  (cand_p),
        .none (empty)
    );

    // Reset image: registers beyond the architectural count start free.
    generate
        for (genvar g = 0; g < PHYS; g++) begin : g_rst
            assign reset_vec[g] = (g >= ARCH);
        end
    endgenerate

    // Next-state of the pool: rebuild on flush, else allocate and release.
    always_comb begin
        if (flush) begin
            free_d = ~cm_used;
        end else begin
            free_d = free_q;
            if (alloc) free_d[cand_p] = 1'b0;
            if (rel_en && rel_p != '0) free_d[rel_p] = 1'b1;
        end
    end

    // Pool register.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= reset_vec;
        else        free_q <= free_d;
    end

    assign free_vec = free_q;
endmodule

// File: rtl/rn_map_table.sv
// Speculative and committed rename maps. Entry 0 of both is fixed at
// physical 0. Reads are combinational from the speculative map. On flush
// the speculative map takes the committed map's next value. Also exports
// the set of physical registers named by the next committed map.
module rn_map_table #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int AW = $clog2(ARCH),
    localparam int PW = $clog2(PHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_a1,
    input  logic [AW-1:0]   rd_a2,
    input  logic [AW-1:0]   rd_ad,
    output logic [PW-1:0]   rd_p1,
    output logic [PW-1:0]   rd_p2,
    output logic [PW-1:0]   rd_pd,
    input  logic            sp_we,
    input  logic [AW-1:0]   sp_a,
    input  logic [PW-1:0]   sp_p,
    input  logic            cm_we,
    input  logic [AW-1:0]   cm_a,
    input  logic [PW-1:0]   cm_p,
    input  logic            flush,
    output logic [PHYS-1:0] cm_used
);
    logic [PW-1:0] spec_q [ARCH];
    logic [PW-1:0] cmt_q  [ARCH];
    logic [PW-1:0] cmt_d  [ARCH];

    assign spec_q[0] = '0;
    assign cmt_q[0]  = '0;
    assign cmt_d[0]  = '0;

    generate
        for (genvar g = 1; g < ARCH; g++) begin : g_ent
            // Committed entry after this cycle's commit.
            always_comb begin
                cmt_d[g] = (cm_we && cm_a == AW'(g)) ? cm_p : cmt_q[g];
            end

            // Committed entry storage.
            always_ff @(posedge clk) begin
                if (!rst_n) cmt_q[g] <= PW'(g);
                else        cmt_q[g] <= cmt_d[g];
            end

            // Speculative entry: identity on reset, reload on flush.
            always_ff @(posedge clk) begin
                if (!rst_n)                         spec_q[g] <= PW'(g);
                else if (flush)                     spec_q[g] <= cmt_d[g];
                else if (sp_we && sp_a == AW'(g))   spec_q[g] <= sp_p;
            end
        end
    endgenerate

    // Lookups through the speculative map.
    assign rd_p1 = spec_q[rd_a1];
    assign rd_p2 = spec_q[rd_a2];
    assign rd_pd = spec_q[rd_ad];

    // Usage set of the committed map, used to rebuild the pool.
    always_comb begin
        cm_used = '0;
        for (int i = 0; i < ARCH; i++) cm_used[cmt_d[i]] = 1'b1;
    end
endmodule

// File: rtl/reg_rename.sv
// Register rename unit. Issue side translates sources and allocates a
// destination from the free pool; commit side promotes mappings in order
// and releases old registers; flush restores the committed state in one
// cycle. Assumes commits are in program order and carry the old register
// reported at issue.
module reg_rename #(
    parameter int ARCH = rn_pkg::ARCH_REGS,
    parameter int PHYS = rn_pkg::PHYS_REGS,
    localparam int AW = $clog2(ARCH),
    localparam int PW = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [AW-1:0] iss_src1,
    input  logic [AW-1:0] iss_src2,
    input  logic [AW-1:0] iss_dst,
    output logic          iss_stall,
    output logic [PW-1:0] iss_psrc1,
    output logic [PW-1:0] iss_psrc2,
    output logic [PW-1:0] iss_pdst,
    output logic [PW-1:0] iss_pold,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_arch,
    input  logic [PW-1:0] cmt_pnew,
    input  logic [PW-1:0] cmt_pold,
    input  logic          flush
);
    logic            need_dst;
    logic            alloc;
    logic            pool_empty;
    logic [PW-1:0]   cand_p;
    logic [PW-1:0]   map_pd;
    logic [PHYS-1:0] cm_used;
    logic [PHYS-1:0] free_vec;
    logic            cm_we;

    // Issue control: a destination needs a register unless it is r0.
    assign need_dst  = iss_valid && (iss_dst != '0);
    assign alloc     = need_dst && !flush && !pool_empty;
    assign iss_stall = iss_valid && (flush || (need_dst && pool_empty));
    assign iss_pdst  = (iss_dst == '0) ? '0 : cand_p;
    assign iss_pold  = map_pd;
    assign cm_we     = cmt_valid && (cmt_arch != '0);

    rn_map_table #(.ARCH(ARCH), .PHYS(PHYS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a1   (iss_src1),
        .rd_a2   (iss_src2),
        .rd_ad   (iss_dst),
        .rd_p1   (iss_psrc1),
        .rd_p2   (iss_psrc2),
        .rd_pd   (map_pd),
        .sp_we   (alloc),
        .sp_a    (iss_dst),
        .sp_p    (cand_p),
        .cm_we   (cm_we),
        .cm_a    (cmt_arch),
        .cm_p    (cmt_pnew),
        .flush   (flush),
        .cm_used (cm_used)
    );

    rn_free_list #(.PHYS(PHYS), .ARCH(ARCH)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc),
        .rel_en   (cm_we),
        .rel_p    (cmt_pold),
        .flush    (flush),
        .cm_used  (cm_used),
        .cand_p   (cand_p),
        .empty    (pool_empty),
        .free_vec (free_vec)
    );
endmodule

// File: rtl/rn_checker.sv
// Cycle-by-cycle properties of the rename unit, bound to its top.
module rn_checker #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int AW = $clog2(ARCH),
    localparam int PW = $clog2(PHYS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc,
    input logic            iss_valid,
    input logic [AW-1:0]   iss_dst,
    input logic            iss_stall,
    input logic [PW-1:0]   iss_pdst,
    input logic            flush,
    input logic [PHYS-1:0] free_vec
);
    // R3: an allocated register is never the fixed zero register.
    p_alloc_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> iss_pdst != '0);

    // R3: an allocated register leaves the pool.
    p_alloc_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> !free_vec[$past(iss_pdst)]);

    // R5: empty pool with a real destination must stall.
    p_stall_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst != '0 && free_vec == '0) |-> iss_stall);

    // R6: the committed map always owns ARCH registers, bounding the pool.
    p_free_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_vec) <= PHYS - ARCH);

    // R7: a flush cycle stalls any issue.
    p_flush_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && iss_valid) |-> iss_stall);

    // R8: after a flush exactly the registers outside the committed map are free.
    p_flush_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $countones(free_vec) == PHYS - ARCH);
endmodule

bind reg_rename rn_checker #(.ARCH(ARCH), .PHYS(PHYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (alloc),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_stall (iss_stall),
    .iss_pdst  (iss_pdst),
    .flush     (flush),
    .free_vec  (free_vec)
);

// File: tb/reg_rename_test.sv
// Directed bench for the rename unit: one task per scenario.
module reg_rename_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [4:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic       iss_stall;
    logic [5:0] iss_psrc1, iss_psrc2, iss_pdst, iss_pold;
    logic       cmt_valid = 1'b0;
    logic [4:0] cmt_arch = '0;
    logic [5:0] cmt_pnew = '0, cmt_pold = '0;
    logic       flush = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    reg_rename uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_dst(iss_dst), .iss_stall(iss_stall),
        .iss_psrc1(iss_psrc1), .iss_psrc2(iss_psrc2),
        .iss_pdst(iss_pdst), .iss_pold(iss_pold),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch),
        .cmt_pnew(cmt_pnew), .cmt_pold(cmt_pold), .flush(flush)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive issue inputs just after a falling edge, then settle.
    task automatic drive(logic v, int s1, int s2, int d);
        @(negedge clk);
        iss_valid = v; iss_src1 = 5'(s1); iss_src2 = 5'(s2); iss_dst = 5'(d);
        cmt_valid = 1'b0; flush = 1'b0;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 0, 0, 0);
    endtask

    task automatic t_reset();
        drive(1'b0, 7, 31, 5);
        check("R1 src 7", int'(iss_psrc1), 7);
        check("R1 src 31", int'(iss_psrc2), 31);
        check("R1 first free", int'(iss_pdst), 32);
        check("R1 no stall idle", int'(iss_stall), 0);
    endtask

    task automatic t_rename();
        drive(1'b1, 3, 4, 3);
        check("R2 src3 before", int'(iss_psrc1), 3);
        check("R2 src4", int'(iss_psrc2), 4);
        check("R3 pdst", int'(iss_pdst), 32);
        check("R3 pold", int'(iss_pold), 3);
        drive(1'b1, 3, 0, 3);
        check("R3 src sees new", int'(iss_psrc1), 32);
        check("R4 src r0", int'(iss_psrc2), 0);
        check("R3 waw pdst", int'(iss_pdst), 33);
        check("R3 waw pold", int'(iss_pold), 32);
        drive(1'b1, 3, 0, 0);
        check("R3 chain src", int'(iss_psrc1), 33);
        check("R4 dst0 pdst", int'(iss_pdst), 0);
        check("R4 dst0 pold", int'(iss_pold), 0);
        check("R4 dst0 no stall", int'(iss_stall), 0);
        drive(1'b0, 0, 0, 9);
        check("R4 dst0 consumed nothing", int'(iss_pdst), 34);
    endtask

    task automatic t_commit();
        @(negedge clk);
        iss_valid = 1'b0; cmt_valid = 1'b1;
        cmt_arch = 5'd3; cmt_pnew = 6'd32; cmt_pold = 6'd3;
        @(negedge clk);
        cmt_pnew = 6'd33; cmt_pold = 6'd32;
        @(negedge clk);
        cmt_valid = 1'b0; iss_dst = 5'd9; #1;
        check("R6 released reused", int'(iss_pdst), 3);
    endtask

    task automatic t_flush();
        drive(1'b1, 0, 0, 7);
        check("R3 spec pdst", int'(iss_pdst), 3);
        check("R3 spec pold", int'(iss_pold), 7);
        drive(1'b1, 7, 0, 8);
        check("R3 spec src", int'(iss_psrc1), 3);
        check("R3 spec pdst2", int'(iss_pdst), 32);
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd9; flush = 1'b1; #1;
        check("R7 flush stalls", int'(iss_stall), 1);
        drive(1'b0, 7, 3, 9);
        check("R7 map restored", int'(iss_psrc1), 7);
        check("R7 committed kept", int'(iss_psrc2), 33);
        check("R8 rebuilt pool", int'(iss_pdst), 3);
        drive(1'b0, 8, 9, 9);
        check("R7 r8 restored", int'(iss_psrc1), 8);
        check("R7 issue in flush ignored", int'(iss_psrc2), 9);
    endtask

    task automatic t_exhaust();
        int taken = 0;
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 0, 0, 10);
            if (!iss_stall) taken++;
        end
        check("R5 allocations until empty", taken, 32);
        check("R5 stall when empty", int'(iss_stall), 1);
        drive(1'b1, 10, 0, 11);
        check("R5 stalled map kept", int'(iss_psrc1), 63);
        check("R5 still stalling", int'(iss_stall), 1);
        @(negedge clk);
        iss_valid = 1'b0; flush = 1'b1;
        cmt_valid = 1'b1; cmt_arch = 5'd12; cmt_pnew = 6'd40; cmt_pold = 6'd12;
        drive(1'b0, 10, 12, 11);
        check("R7 r10 after flush", int'(iss_psrc1), 10);
        check("R7 commit during flush", int'(iss_psrc2), 40);
        check("R8 pool after flush", int'(iss_pdst), 3);
        check("R8 no stall after flush", int'(iss_stall), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_rename();
                t_commit();
                t_flush();
                t_exhaust();
                idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule